// File: doc/BRIEF.md
# Accumulator Transfer and Stack Unit

This unit carries out single-cycle byte transfer micro-operations that centre on an 8-bit accumulator. It also holds an 8-bit stack pointer, a 16-bit data pointer and an 8-bit status word. A sequencer outside the unit presents one operation per cycle. Each operation comes as a 4-bit code with a byte operand, a 16-bit immediate, the current program counter and an 8-bit index register value. Any result bound for an outside destination comes back on a registered write-back port.

The stack lives in a 256-byte RAM inside the unit and grows toward higher addresses. A push increments the pointer before it writes. A pop reads before it decrements. The unit exchanges either the whole operand byte or only its low nibble with the accumulator. It forms table-lookup addresses as a selectable 16-bit base plus the accumulator. It also presents the address and data for a move to external memory, but it does not drive that bus.

Top module: `acc_xfer_unit`

## Requirements
- R1: After reset the accumulator, data pointer, status word, lookup address, external address and external data are all zero, the stack pointer is 8'h07, and `wb_valid_o` is low.
- R2: Push (code 2) sets the stack pointer to its old value plus one and stores the operand at that new location.
- R3: Pop (code 3) returns the byte at the current stack pointer on `wb_data_o`, with `wb_valid_o` high for the following cycle only, and then decrements the stack pointer.
- R4: Full exchange (code 4) loads the operand into the accumulator and returns the old accumulator on the write-back port.
- R5: Nibble exchange (code 5) replaces only accumulator bits 3..0 with operand bits 3..0. The write-back byte is operand bits 7..4 over old accumulator bits 3..0.
- R6: Lookup with the data-pointer base (code 9) or the program-counter base (code 10) sets `lookup_addr_o` to the base plus the zero-extended accumulator, modulo 2^16.
- R7: Immediate load (code 6) writes all 16 bits of `imm_i` into the data pointer in one operation.
- R8: The status word changes only on move-to-status (code 7, from the operand) and pop-to-status (code 8, from the stack, which also decrements the pointer). Every other operation leaves it unchanged.
- R9: The stack pointer wraps modulo 256: a push at 8'hFF gives 8'h00, and a pop at 8'h00 gives 8'hFF.
- R10: External address from the data pointer (code 11) or from the zero-extended index register (code 12) appears on `xmem_addr_o`, and the accumulator appears on `xmem_data_o`.
- R11: Move-to-accumulator (code 1) and move-to-stack-pointer (code 13) load the operand. With `op_valid_i` low, no state changes and `wb_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Byte operand |
| imm_i | input | 16 | Immediate for data-pointer load |
| pc_i | input | 16 | Program counter used as lookup base |
| idx_i | input | 8 | Index register for external address |
| acc_o | output | 8 | Accumulator |
| sp_o | output | 8 | Stack pointer |
| dptr_o | output | 16 | Data pointer |
| psw_o | output | 8 | Status word |
| wb_valid_o | output | 1 | Write-back byte valid |
| wb_data_o | output | 8 | Write-back byte |
| lookup_addr_o | output | 16 | Table-lookup address |
| xmem_addr_o | output | 16 | External memory address |
| xmem_data_o | output | 8 | External memory write data |

## Verification
The bound assertions check the rules that compare one cycle with the next, on every cycle:
- the stack-pointer step for push and pop;
- the accumulator and write-back bytes after both kinds of exchange;
- the data-pointer load;
- the status word holding its value outside its two writers;
- a quiet cycle changing nothing.

Some behaviour depends on earlier operations, and only the bench's scenarios can show it:
- that the byte a pop returns is the one an earlier push stored at that pointer;
- the wrap of the pointer across 8'hFF and 8'h00;
- the 16-bit wrap of the lookup sum;
- which base or index feeds the address outputs.

// File: rtl/acc_xfer_pkg.sv
package acc_xfer_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_MOV_A      = 4'd1,
        OP_PUSH       = 4'd2,
        OP_POP        = 4'd3,
        OP_XCH        = 4'd4,
        OP_XCHD       = 4'd5,
        OP_LD_DPTR    = 4'd6,
        OP_MOV_PSW    = 4'd7,
        OP_POP_PSW    = 4'd8,
        OP_LKUP_DPTR  = 4'd9,
        OP_LKUP_PC    = 4'd10,
        OP_XADDR_DPTR = 4'd11,
        OP_XADDR_IDX  = 4'd12,
        OP_MOV_SP     = 4'd13
    } xfer_op_e;

    localparam int unsigned OP_W = 4;

endpackage

// File: rtl/axu_stack_ram.sv
module axu_stack_ram #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned DEPTH = 2 ** AW;

    logic [DW-1:0] mem_q [DEPTH];

    // synchronous write port
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // combinational read port
    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/axu_nibble_xchg.sv
module axu_nibble_xchg #(
    parameter int unsigned DW = 8
) (
    input  logic          full_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    output logic [DW-1:0] acc_new_o,
    output logic [DW-1:0] opnd_new_o
);
    localparam int unsigned LO_W = DW / 2;
    localparam int unsigned HI_W = DW - LO_W;

    logic [DW-1:0] part_acc;
    logic [DW-1:0] part_opnd;

    // low half exchanged, upper halves kept in place
    assign part_acc  = {acc_i[DW-1 -: HI_W], opnd_i[LO_W-1:0]};
    assign part_opnd = {opnd_i[DW-1 -: HI_W], acc_i[LO_W-1:0]};

    always_comb begin
        if (full_i) begin
            acc_new_o  = opnd_i;
            opnd_new_o = acc_i;
        end else begin
            acc_new_o  = part_acc;
            opnd_new_o = part_opnd;
        end
    end

endmodule

// File: rtl/axu_addr_gen.sv
module axu_addr_gen #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 16
) (
    input  logic          base_is_pc_i,
    input  logic          xaddr_is_idx_i,
    input  logic [AW-1:0] dptr_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] idx_i,
    output logic [AW-1:0] lookup_addr_o,
    output logic [AW-1:0] xmem_addr_o
);
    localparam int unsigned PAD_W = AW - DW;

    logic [AW-1:0] acc_ext;
    logic [AW-1:0] idx_ext;
    logic [AW-1:0] base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign acc_ext = {{PAD_W{1'b0}}, acc_i};
            assign idx_ext = {{PAD_W{1'b0}}, idx_i};
        end else begin : g_nopad
            assign acc_ext = acc_i[AW-1:0];
            assign idx_ext = idx_i[AW-1:0];
        end
    endgenerate

    assign base          = base_is_pc_i ? pc_i : dptr_i;
    assign lookup_addr_o = base + acc_ext;
    assign xmem_addr_o   = xaddr_is_idx_i ? idx_ext : dptr_i;

endmodule

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit
    import acc_xfer_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 16,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          op_valid_i,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [AW-1:0] imm_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] idx_i,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] sp_o,
    output logic [AW-1:0] dptr_o,
    output logic [DW-1:0] psw_o,
    output logic          wb_valid_o,
    output logic [DW-1:0] wb_data_o,
    output logic [AW-1:0] lookup_addr_o,
    output logic [AW-1:0] xmem_addr_o,
    output logic [DW-1:0] xmem_data_o
);
    localparam logic [DW-1:0] SP_ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] sp;
        logic [AW-1:0] dptr;
        logic [DW-1:0] psw;
        logic          wb_valid;
        logic [DW-1:0] wb_data;
        logic [AW-1:0] lookup;
        logic [AW-1:0] xaddr;
        logic [DW-1:0] xdata;
    } axu_state_t;

    axu_state_t state_d, state_q;
    xfer_op_e   op;

    logic          ram_we;
    logic [DW-1:0] ram_waddr;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] sp_inc;
    logic [DW-1:0] sp_dec;
    logic          xchg_full;
    logic [DW-1:0] xchg_acc;
    logic [DW-1:0] xchg_opnd;
    logic          base_is_pc;
    logic          xaddr_is_idx;
    logic [AW-1:0] lookup_sum;
    logic [AW-1:0] xaddr_sel;

    assign op     = xfer_op_e'(op_i);
    assign sp_inc = state_q.sp + SP_ONE;
    assign sp_dec = state_q.sp - SP_ONE;

    assign xchg_full    = (op == OP_XCH);
    assign base_is_pc   = (op == OP_LKUP_PC);
    assign xaddr_is_idx = (op == OP_XADDR_IDX);

    axu_stack_ram #(
        .DW (DW),
        .AW (DW)
    ) stack_i (
        .clk_i   (clk_i),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (opnd_i),
        .raddr_i (state_q.sp),
        .rdata_o (ram_rdata)
    );

    axu_nibble_xchg #(
        .DW (DW)
    ) xchg_i (
        .full_i     (xchg_full),
        .acc_i      (state_q.acc),
        .opnd_i     (opnd_i),
        .acc_new_o  (xchg_acc),
        .opnd_new_o (xchg_opnd)
    );

    axu_addr_gen #(
        .DW (DW),
        .AW (AW)
    ) addr_i (
        .base_is_pc_i   (base_is_pc),
        .xaddr_is_idx_i (xaddr_is_idx),
        .dptr_i         (state_q.dptr),
        .pc_i           (pc_i),
        .acc_i          (state_q.acc),
        .idx_i          (idx_i),
        .lookup_addr_o  (lookup_sum),
        .xmem_addr_o    (xaddr_sel)
    );

    // next-state computation
    always_comb begin
        state_d          = state_q;
        state_d.wb_valid = 1'b0;
        ram_we           = 1'b0;
        ram_waddr        = sp_inc;
        if (op_valid_i) begin
            unique case (op)
                OP_MOV_A:  state_d.acc = opnd_i;
                OP_MOV_SP: state_d.sp  = opnd_i;
                OP_PUSH: begin
                    ram_we     = 1'b1;
                    state_d.sp = sp_inc;
                end
                OP_POP: begin
                    state_d.wb_valid = 1'b1;
                    state_d.wb_data  = ram_rdata;
                    state_d.sp       = sp_dec;
                end
                OP_XCH, OP_XCHD: begin
                    state_d.acc      = xchg_acc;
                    state_d.wb_valid = 1'b1;
                    state_d.wb_data  = xchg_opnd;
                end
                OP_LD_DPTR: state_d.dptr = imm_i;
                OP_MOV_PSW: state_d.psw  = opnd_i;
                OP_POP_PSW: begin
                    state_d.psw = ram_rdata;
                    state_d.sp  = sp_dec;
                end
                OP_LKUP_DPTR, OP_LKUP_PC: state_d.lookup = lookup_sum;
                OP_XADDR_DPTR, OP_XADDR_IDX: begin
                    state_d.xaddr = xaddr_sel;
                    state_d.xdata = state_q.acc;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= '0;
            state_q.sp <= SP_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o         = state_q.acc;
    assign sp_o          = state_q.sp;
    assign dptr_o        = state_q.dptr;
    assign psw_o         = state_q.psw;
    assign wb_valid_o    = state_q.wb_valid;
    assign wb_data_o     = state_q.wb_data;
    assign lookup_addr_o = state_q.lookup;
    assign xmem_addr_o   = state_q.xaddr;
    assign xmem_data_o   = state_q.xdata;

endmodule

// File: rtl/acc_xfer_chk.sv
module acc_xfer_chk
    import acc_xfer_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          op_valid_i,
    input logic [3:0]    op_i,
    input logic [DW-1:0] opnd_i,
    input logic [AW-1:0] imm_i,
    input logic [DW-1:0] acc_o,
    input logic [DW-1:0] sp_o,
    input logic [AW-1:0] dptr_o,
    input logic [DW-1:0] psw_o,
    input logic          wb_valid_o,
    input logic [DW-1:0] wb_data_o
);
    localparam int unsigned LO_W = DW / 2;

    logic is_push, is_pop, is_xch, is_xchd, is_ldp, is_psw_wr;

    assign is_push   = op_valid_i && (op_i == OP_PUSH);
    assign is_pop    = op_valid_i && (op_i == OP_POP || op_i == OP_POP_PSW);
    assign is_xch    = op_valid_i && (op_i == OP_XCH);
    assign is_xchd   = op_valid_i && (op_i == OP_XCHD);
    assign is_ldp    = op_valid_i && (op_i == OP_LD_DPTR);
    assign is_psw_wr = op_valid_i && (op_i == OP_MOV_PSW || op_i == OP_POP_PSW);

    // R2
    push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_push |=> sp_o == DW'($past(sp_o) + DW'(1)));

    // R3
    pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_pop |=> sp_o == DW'($past(sp_o) - DW'(1)));

    // R4
    xch_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_xch |=> acc_o == $past(opnd_i) && wb_valid_o && wb_data_o == $past(acc_o));

    // R5
    xchd_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_xchd |=> acc_o[DW-1:LO_W] == $past(acc_o[DW-1:LO_W])
                 && acc_o[LO_W-1:0] == $past(opnd_i[LO_W-1:0])
                 && wb_data_o[DW-1:LO_W] == $past(opnd_i[DW-1:LO_W])
                 && wb_data_o[LO_W-1:0] == $past(acc_o[LO_W-1:0]));

    // R7
    dptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_ldp |=> dptr_o == $past(imm_i));

    // R8
    psw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_psw_wr |=> $stable(psw_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> !wb_valid_o && $stable(acc_o) && $stable(sp_o) && $stable(dptr_o));

endmodule

bind acc_xfer_unit acc_xfer_chk #(
    .DW (DW),
    .AW (AW)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .opnd_i     (opnd_i),
    .imm_i      (imm_i),
    .acc_o      (acc_o),
    .sp_o       (sp_o),
    .dptr_o     (dptr_o),
    .psw_o      (psw_o),
    .wb_valid_o (wb_valid_o),
    .wb_data_o  (wb_data_o)
);

// File: tb/acc_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module acc_xfer_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [7:0]  opnd = 8'h00;
    logic [15:0] imm = 16'h0000;
    logic [15:0] pc = 16'h0000;
    logic [7:0]  idx = 8'h00;
    logic [7:0]  acc, sp, psw, wb_data, xdata;
    logic [15:0] dptr, lookup, xaddr;
    logic        wb_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    acc_xfer_unit dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .op_valid_i    (op_valid),
        .op_i          (op),
        .opnd_i        (opnd),
        .imm_i         (imm),
        .pc_i          (pc),
        .idx_i         (idx),
        .acc_o         (acc),
        .sp_o          (sp),
        .dptr_o        (dptr),
        .psw_o         (psw),
        .wb_valid_o    (wb_valid),
        .wb_data_o     (wb_data),
        .lookup_addr_o (lookup),
        .xmem_addr_o   (xaddr),
        .xmem_data_o   (xdata)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] opnd;
        logic [7:0] acc;
        logic [7:0] sp;
        logic       wbv;
        logic [7:0] wb;
        logic [7:0] psw;
    } vec_t;

    // stack, exchange and status-word sequence from reset (R2 R3 R4 R5 R8 R11)
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  8'h5A, 8'h5A, 8'h07, 1'b0, 8'h00, 8'h00},
        '{4'd2,  8'h11, 8'h5A, 8'h08, 1'b0, 8'h00, 8'h00},
        '{4'd2,  8'h22, 8'h5A, 8'h09, 1'b0, 8'h00, 8'h00},
        '{4'd4,  8'h3C, 8'h3C, 8'h09, 1'b1, 8'h5A, 8'h00},
        '{4'd5,  8'hA7, 8'h37, 8'h09, 1'b1, 8'hAC, 8'h00},
        '{4'd7,  8'h81, 8'h37, 8'h09, 1'b0, 8'h00, 8'h81},
        '{4'd3,  8'h00, 8'h37, 8'h08, 1'b1, 8'h22, 8'h81},
        '{4'd4,  8'h00, 8'h00, 8'h08, 1'b1, 8'h37, 8'h81},
        '{4'd8,  8'h00, 8'h00, 8'h07, 1'b0, 8'h00, 8'h11},
        '{4'd2,  8'hFF, 8'h00, 8'h08, 1'b0, 8'h00, 8'h11},
        '{4'd1,  8'h9E, 8'h9E, 8'h08, 1'b0, 8'h00, 8'h11},
        '{4'd5,  8'h4B, 8'h9B, 8'h08, 1'b1, 8'h4E, 8'h11},
        '{4'd3,  8'h00, 8'h9B, 8'h07, 1'b1, 8'hFF, 8'h11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] code, input logic [7:0] d);
        @(negedge clk);
        op_valid = 1'b1;
        op       = code;
        opnd     = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<5000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset acc/sp/psw/wbv", {acc, sp, psw, 7'd0, wb_valid}, {8'h00, 8'h07, 8'h00, 8'h00});
        check("R1 reset dptr/lookup", {dptr, lookup}, 32'h0);
        check("R1 reset xaddr/xdata", {xaddr, xdata}, 24'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            do_op(VECS[i].op, VECS[i].opnd);
            check($sformatf("R2/R3/R4/R5/R8 vec %0d acc,sp,psw,wbv", i),
                  {acc, sp, psw, 7'd0, wb_valid},
                  {VECS[i].acc, VECS[i].sp, VECS[i].psw, 7'd0, VECS[i].wbv});
            if (VECS[i].wbv)
                check($sformatf("R3/R4/R5 vec %0d wb_data", i), {24'd0, wb_data}, {24'd0, VECS[i].wb});
        end

        // R7 immediate load fills both halves
        imm = 16'h12F0;
        do_op(4'd6, 8'h00);
        check("R7 dptr load", {16'd0, dptr}, 32'h12F0);
        check("R8 psw kept across dptr load", {24'd0, psw}, 32'h11);

        // R6 lookup from both bases
        do_op(4'd1, 8'hFF);
        do_op(4'd9, 8'h00);
        check("R6 lookup dptr base", {16'd0, lookup}, 32'h13EF);
        pc = 16'hFFF0;
        do_op(4'd10, 8'h00);
        check("R6 lookup pc base wraps", {16'd0, lookup}, 32'h00EF);

        // R10 external address selection
        do_op(4'd11, 8'h00);
        check("R10 xaddr from dptr", {8'd0, xaddr, xdata}, {8'd0, 16'h12F0, 8'hFF});
        idx = 8'h5C;
        do_op(4'd12, 8'h00);
        check("R10 xaddr from index", {16'd0, xaddr}, 32'h005C);

        // R11 idle cycle leaves the state alone
        @(negedge clk);
        op = 4'd1;
        opnd = 8'h00;
        op_valid = 1'b0;
        @(negedge clk);
        check("R11 idle acc/wbv", {acc, 7'd0, wb_valid}, {8'hFF, 8'h00});

        // R9 pointer wrap in both directions
        do_op(4'd13, 8'hFF);
        check("R11 move to sp", {24'd0, sp}, 32'hFF);
        do_op(4'd2, 8'h66);
        check("R9 push wraps FF to 00", {24'd0, sp}, 32'h00);
        do_op(4'd3, 8'h00);
        check("R9 pop wraps 00 to FF", {sp, 7'd0, wb_valid, wb_data}, {8'hFF, 8'h01, 8'h66});
        @(negedge clk);
        check("R3 wb_valid single cycle", {31'd0, wb_valid}, 32'd0);
        check("R8 psw kept to end", {24'd0, psw}, 32'h11);

        // R1 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 second reset", {acc, sp, dptr}, {8'h00, 8'h07, 16'h0000});
        finish_run();
    end

endmodule